// File: doc/BRIEF.md
# PC Card DMA Cycle Generator

This block sits between a host bus that runs ISA-style DMA handshakes and a pair of PC Card sockets. For every host transfer it decides which socket gets the cycle and drives that socket's five card control strobes: output enable, write enable, I/O read, I/O write and register select, all active low. Common-memory, attribute-memory and I/O cycles follow the usual PC Card encodings. When the host acknowledges a DMA transfer and a socket has DMA enabled, the block issues a fourth, non-standard cycle type. In that cycle the I/O strobes move the data and register select stays high, which a DMA-capable card reads as "this is DMA, not I/O". The two memory strobes are then free, so they carry the host terminal count to the card.

The host DMA request and acknowledge wires are shared by both sockets. For that reason at most one socket may take part in DMA at any time. Each socket has a two-bit DMA enable field. If both fields are nonzero, the lowest-numbered enabled socket wins and the other is masked, both for DMA cycles and for forwarding its card DMA request to the host. The card transfer width always copies the width of the host cycle. All outputs are registered, so they change one clock after the inputs.

Top module: `pcdma_cycle_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, every card strobe and `card_reg_n` bit goes to 1, and every `card_wide` bit and `host_dreq` go to 0, whatever the other inputs are.
- R2: Outputs are registered and respond to inputs at the first rising edge. A cycle takes place only when exactly one of `host_rd`/`host_wr` is high. With neither or both high, or with `req_space` = 2'b11 and no DMA cycle, every strobe of every socket is 1. At most one socket has a strobe low at a time.
- R3: Common memory (`req_space` = 2'b00) on socket `sock_sel`: `card_oe_n` is low for a read, `card_we_n` is low for a write, both I/O strobes are 1, and `card_reg_n` is 1.
- R4: Attribute memory (`req_space` = 2'b01): the same strobes as R3, but `card_reg_n` is 0.
- R5: I/O (`req_space` = 2'b10): `card_iord_n` is low for a read, `card_iowr_n` is low for a write, `card_oe_n`/`card_we_n` are 1, and `card_reg_n` is 0.
- R6: With `host_dack` high and at least one nonzero DMA enable field, a DMA cycle goes to the granted socket regardless of `sock_sel` and `req_space`. A host read drives `card_iord_n` low, a host write drives `card_iowr_n` low, and `card_reg_n` stays 1.
- R7: In a DMA cycle, `card_oe_n` and `card_we_n` are both 0 when `host_tc` is high and both 1 when it is low. Outside DMA cycles `host_tc` has no effect.
- R8: When every DMA enable field is zero, `host_dack` is ignored and the cycle is the standard one chosen by `req_space` and `sock_sel`.
- R9: Socket i's DMA enable field is `dma_mode[2i+1:2i]`. If more than one field is nonzero, only the lowest-numbered enabled socket is granted. The others receive no DMA cycle.
- R10: `card_wide` of the socket that receives the cycle equals `host_wide`. Every other `card_wide` bit is 0.
- R11: `host_dreq` equals, one clock later, the `card_dreq` bit of the granted socket. It is 0 when no socket is granted, and the requests of masked sockets are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_dack | input | 1 | Host DMA acknowledge, active high |
| host_rd | input | 1 | Host read strobe, active high |
| host_wr | input | 1 | Host write strobe, active high |
| host_tc | input | 1 | Host DMA terminal count, active high |
| host_wide | input | 1 | Host cycle is 16-bit when 1 |
| req_space | input | 2 | Standard cycle space: 00 common, 01 attribute, 10 I/O, 11 none |
| sock_sel | input | SEL_W (1) | Socket addressed by a standard cycle |
| dma_mode | input | NSOCK*MODE_W (4) | Per-socket DMA enable fields |
| card_dreq | input | NSOCK (2) | DMA request from each card, active high |
| card_oe_n | output | NSOCK (2) | Output enable per socket, active low |
| card_we_n | output | NSOCK (2) | Write enable per socket, active low |
| card_iord_n | output | NSOCK (2) | I/O read per socket, active low |
| card_iowr_n | output | NSOCK (2) | I/O write per socket, active low |
| card_reg_n | output | NSOCK (2) | Register select per socket, active low |
| card_wide | output | NSOCK (2) | 16-bit card cycle indication per socket |
| host_dreq | output | 1 | DMA request forwarded to the host |

## Verification
The bench builds the block with its defaults, NSOCK = 2 and MODE_W = 2. This is the smallest configuration in which the shared-handshake exclusion can be tested: both enable fields can be set together, and the bench can check that socket 1 is masked while socket 0 takes the DMA cycle. With two sockets the bench can also show that a DMA cycle ignores `sock_sel`, and that a standard cycle lands on either socket while the other socket stays idle. The two-bit field lets the bench try several nonzero enable codes and confirm that each of them enables DMA in the same way.

// File: rtl/pcdma_pkg.sv
// Package: shared types for the PC Card DMA cycle generator.
// Assumes strobes are active low and a cycle type is decided per host cycle.
package pcdma_pkg;

    // Standard cycle space requested by the host decode logic
    typedef enum logic [1:0] {
        SPACE_COMMON = 2'b00,
        SPACE_ATTR   = 2'b01,
        SPACE_IO     = 2'b10,
        SPACE_NONE   = 2'b11
    } space_e;

    // Card cycle type chosen for the current host cycle
    typedef enum logic [2:0] {
        CYC_NONE   = 3'd0,
        CYC_COMMON = 3'd1,
        CYC_ATTR   = 3'd2,
        CYC_IO     = 3'd3,
        CYC_DMA    = 3'd4
    } cyc_e;

    // Card control strobes, all active low
    typedef struct packed {
        logic oe_n;
        logic we_n;
        logic iord_n;
        logic iowr_n;
        logic reg_n;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{oe_n: 1'b1, we_n: 1'b1, iord_n: 1'b1,
                                        iowr_n: 1'b1, reg_n: 1'b1};

endpackage

// File: rtl/pcdma_grant.sv
// Module: pcdma_grant
// Picks the one socket allowed to use the shared DMA handshake.
// A socket asks for DMA when its enable field is nonzero. When several ask,
// the lowest index wins. Purely combinational.
module pcdma_grant #(
    parameter int NSOCK  = 2,
    parameter int MODE_W = 2
) (
    input  logic [NSOCK*MODE_W-1:0] dma_mode,
    output logic [NSOCK-1:0]        grant,
    output logic                    any_grant
);

    logic [NSOCK-1:0] wants;

    // Reduce each socket's enable field to one request bit
    for (genvar s = 0; s < NSOCK; s++) begin : g_want
        assign wants[s] = |dma_mode[s*MODE_W +: MODE_W];
    end

    // Fixed priority: keep only the lowest requesting socket
    always_comb begin
        grant = '0;
        for (int i = 0; i < NSOCK; i++) begin
            if (wants[i] && (grant == '0)) begin
                grant[i] = 1'b1;
            end
        end
    end

    assign any_grant = |wants;

endmodule

// File: rtl/pcdma_classify.sv
// Module: pcdma_classify
// Decides the card cycle type and the target socket for one host cycle.
// Assumes exactly one of rd/wr marks a live cycle. A DMA acknowledge with a
// granted socket overrides the standard decode and the socket select.
module pcdma_classify
    import pcdma_pkg::*;
#(
    parameter int NSOCK = 2,
    parameter int SEL_W = 1
) (
    input  logic             host_dack,
    input  logic             host_rd,
    input  logic             host_wr,
    input  logic [1:0]       req_space,
    input  logic [SEL_W-1:0] sock_sel,
    input  logic [NSOCK-1:0] grant,
    input  logic             any_grant,
    output cyc_e             cyc,
    output logic [NSOCK-1:0] target
);

    logic             live;
    logic [NSOCK-1:0] sel_hot;

    assign live = host_rd ^ host_wr;

    // Decode the socket select into one-hot form
    always_comb begin
        sel_hot = '0;
        for (int i = 0; i < NSOCK; i++) begin
            sel_hot[i] = (sock_sel == SEL_W'(i));
        end
    end

    // Choose the cycle type and which socket receives it
    always_comb begin
        cyc    = CYC_NONE;
        target = '0;
        if (live) begin
            if (host_dack && any_grant) begin
                cyc    = CYC_DMA;
                target = grant;
            end else begin
                target = sel_hot;
                case (space_e'(req_space))
                    SPACE_COMMON: cyc = CYC_COMMON;
                    SPACE_ATTR:   cyc = CYC_ATTR;
                    SPACE_IO:     cyc = CYC_IO;
                    default: begin
                        cyc    = CYC_NONE;
                        target = '0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/pcdma_encode.sv
// Module: pcdma_encode
// Maps a cycle type and a direction to the five card strobe levels.
// In a DMA cycle the I/O strobes carry the data and register select stays
// high. The memory strobes show terminal count. Combinational.
module pcdma_encode
    import pcdma_pkg::*;
(
    input  cyc_e    cyc,
    input  logic    host_rd,
    input  logic    host_wr,
    input  logic    host_tc,
    output strobe_t strobe
);

    // Build the strobe pattern for the chosen cycle type
    always_comb begin
        strobe = STROBE_IDLE;
        case (cyc)
            CYC_COMMON: begin
                strobe.oe_n = ~host_rd;
                strobe.we_n = ~host_wr;
            end
            CYC_ATTR: begin
                strobe.oe_n  = ~host_rd;
                strobe.we_n  = ~host_wr;
                strobe.reg_n = 1'b0;
            end
            CYC_IO: begin
                strobe.iord_n = ~host_rd;
                strobe.iowr_n = ~host_wr;
                strobe.reg_n  = 1'b0;
            end
            CYC_DMA: begin
                strobe.iord_n = ~host_rd;
                strobe.iowr_n = ~host_wr;
                strobe.oe_n   = ~host_tc;
                strobe.we_n   = ~host_tc;
            end
            default: strobe = STROBE_IDLE;
        endcase
    end

endmodule

// File: rtl/pcdma_sock_reg.sv
// Module: pcdma_sock_reg
// Output register for one socket: holds its strobes and width bit.
// A socket that is not targeted is driven idle. Synchronous active-low reset.
module pcdma_sock_reg
    import pcdma_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    hit,
    input  logic    host_wide,
    input  strobe_t strobe_d,
    output strobe_t strobe_q,
    output logic    wide_q
);

    // Register this socket's strobes, idle when not addressed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= STROBE_IDLE;
            wide_q   <= 1'b0;
        end else begin
            strobe_q <= hit ? strobe_d : STROBE_IDLE;
            wide_q   <= hit & host_wide;
        end
    end

endmodule

// File: rtl/pcdma_cycle_gen.sv
// Module: pcdma_cycle_gen (top)
// Turns host memory, I/O and DMA-acknowledge cycles into card strobe patterns
// for NSOCK sockets. DMA goes to the single granted socket, and the card DMA
// request of that socket alone is forwarded to the host. All outputs are
// registered, with one clock of latency.
module pcdma_cycle_gen
    import pcdma_pkg::*;
#(
    parameter int NSOCK  = 2,
    parameter int MODE_W = 2,
    localparam int SEL_W = (NSOCK > 1) ? $clog2(NSOCK) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    host_dack,
    input  logic                    host_rd,
    input  logic                    host_wr,
    input  logic                    host_tc,
    input  logic                    host_wide,
    input  logic [1:0]              req_space,
    input  logic [SEL_W-1:0]        sock_sel,
    input  logic [NSOCK*MODE_W-1:0] dma_mode,
    input  logic [NSOCK-1:0]        card_dreq,
    output logic [NSOCK-1:0]        card_oe_n,
    output logic [NSOCK-1:0]        card_we_n,
    output logic [NSOCK-1:0]        card_iord_n,
    output logic [NSOCK-1:0]        card_iowr_n,
    output logic [NSOCK-1:0]        card_reg_n,
    output logic [NSOCK-1:0]        card_wide,
    output logic                    host_dreq
);

    logic [NSOCK-1:0] grant;
    logic             any_grant;
    cyc_e             cyc;
    logic [NSOCK-1:0] target;
    strobe_t          strobe_d;

    pcdma_grant #(.NSOCK(NSOCK), .MODE_W(MODE_W)) grant_i (
        .dma_mode  (dma_mode),
        .grant     (grant),
        .any_grant (any_grant)
    );

    pcdma_classify #(.NSOCK(NSOCK), .SEL_W(SEL_W)) classify_i (
        .host_dack (host_dack),
        .host_rd   (host_rd),
        .host_wr   (host_wr),
        .req_space (req_space),
        .sock_sel  (sock_sel),
        .grant     (grant),
        .any_grant (any_grant),
        .cyc       (cyc),
        .target    (target)
    );

    pcdma_encode encode_i (
        .cyc     (cyc),
        .host_rd (host_rd),
        .host_wr (host_wr),
        .host_tc (host_tc),
        .strobe  (strobe_d)
    );

    // One output register per socket, unpacked onto the port vectors
    for (genvar s = 0; s < NSOCK; s++) begin : g_sock
        strobe_t strobe_q;
        pcdma_sock_reg sreg_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .hit       (target[s]),
            .host_wide (host_wide),
            .strobe_d  (strobe_d),
            .strobe_q  (strobe_q),
            .wide_q    (card_wide[s])
        );
        assign card_oe_n[s]   = strobe_q.oe_n;
        assign card_we_n[s]   = strobe_q.we_n;
        assign card_iord_n[s] = strobe_q.iord_n;
        assign card_iowr_n[s] = strobe_q.iowr_n;
        assign card_reg_n[s]  = strobe_q.reg_n;
    end

    // Forward only the granted socket's DMA request to the host
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_dreq <= 1'b0;
        end else begin
            host_dreq <= |(card_dreq & grant);
        end
    end

endmodule

// File: rtl/pcdma_cycle_gen_chk.sv
// Module: pcdma_cycle_gen_chk
// Property checker for pcdma_cycle_gen, attached with bind. It relates the
// host inputs of one cycle to the card outputs of the next.
module pcdma_cycle_gen_chk #(
    parameter int NSOCK  = 2,
    parameter int MODE_W = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    host_dack,
    input logic                    host_rd,
    input logic                    host_wr,
    input logic                    host_tc,
    input logic [NSOCK*MODE_W-1:0] dma_mode,
    input logic [NSOCK-1:0]        card_oe_n,
    input logic [NSOCK-1:0]        card_we_n,
    input logic [NSOCK-1:0]        card_iord_n,
    input logic [NSOCK-1:0]        card_iowr_n,
    input logic [NSOCK-1:0]        card_reg_n,
    input logic [NSOCK-1:0]        card_wide,
    input logic                    host_dreq
);

    logic [NSOCK-1:0] sock_busy;
    assign sock_busy = ~(card_oe_n & card_we_n & card_iord_n & card_iowr_n);

    a_r2_idle_without_dir: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_rd ^ host_wr) |=> (sock_busy == '0));

    a_r2_one_socket: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sock_busy));

    a_r6_dma_reg_high: assert property (@(posedge clk) disable iff (!rst_n)
        (host_dack && (|dma_mode) && (host_rd ^ host_wr)) |=> (&card_reg_n));

    a_r7_no_tc_mem_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (host_dack && (|dma_mode) && !host_tc && (host_rd ^ host_wr))
        |=> ((&card_oe_n) && (&card_we_n)));

    a_r10_wide_one_socket: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(card_wide));

    a_r11_no_dreq_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_mode == '0) |=> !host_dreq);

endmodule

bind pcdma_cycle_gen pcdma_cycle_gen_chk #(.NSOCK(NSOCK), .MODE_W(MODE_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_dack   (host_dack),
    .host_rd     (host_rd),
    .host_wr     (host_wr),
    .host_tc     (host_tc),
    .dma_mode    (dma_mode),
    .card_oe_n   (card_oe_n),
    .card_we_n   (card_we_n),
    .card_iord_n (card_iord_n),
    .card_iowr_n (card_iowr_n),
    .card_reg_n  (card_reg_n),
    .card_wide   (card_wide),
    .host_dreq   (host_dreq)
);

// File: tb/pcdma_cycle_gen_tb_top.sv
`timescale 1ns/1ps
// Bench for pcdma_cycle_gen. It walks a vector table, then runs directed
// tests for reset and latency. Strobe nibbles are written {oe,we,iord,iowr,reg}.
module pcdma_cycle_gen_tb_top;

    localparam int NSOCK  = 2;
    localparam int MODE_W = 2;

    typedef struct packed {
        logic [3:0] req;
        logic       dack;
        logic       rd;
        logic       wr;
        logic       tc;
        logic       wide;
        logic [1:0] space;
        logic       sel;
        logic [3:0] mode;   // {socket1 field, socket0 field}
        logic [1:0] dreq;
        logic [4:0] e1;     // expected socket 1 strobes
        logic [4:0] e0;     // expected socket 0 strobes
        logic [1:0] ewide;
        logic       edreq;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        // R2 idle
        '{4'd2, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,1'b0,4'h0,2'd0, 5'b11111,5'b11111,2'b00,1'b0},
        // R3 common read socket 0, wide
        '{4'd3, 1'b0,1'b1,1'b0,1'b0,1'b1, 2'd0,1'b0,4'h0,2'd0, 5'b11111,5'b01111,2'b01,1'b0},
        // R3 common write socket 1
        '{4'd3, 1'b0,1'b0,1'b1,1'b0,1'b0, 2'd0,1'b1,4'h0,2'd0, 5'b10111,5'b11111,2'b00,1'b0},
        // R4 attribute read socket 0
        '{4'd4, 1'b0,1'b1,1'b0,1'b0,1'b0, 2'd1,1'b0,4'h0,2'd0, 5'b11111,5'b01110,2'b00,1'b0},
        // R4 attribute write socket 1, wide
        '{4'd4, 1'b0,1'b0,1'b1,1'b0,1'b1, 2'd1,1'b1,4'h0,2'd0, 5'b10110,5'b11111,2'b10,1'b0},
        // R5 io read socket 0
        '{4'd5, 1'b0,1'b1,1'b0,1'b0,1'b0, 2'd2,1'b0,4'h0,2'd0, 5'b11111,5'b11010,2'b00,1'b0},
        // R5 io write socket 1
        '{4'd5, 1'b0,1'b0,1'b1,1'b0,1'b0, 2'd2,1'b1,4'h0,2'd0, 5'b11100,5'b11111,2'b00,1'b0},
        // R2 both strobes high
        '{4'd2, 1'b0,1'b1,1'b1,1'b0,1'b0, 2'd0,1'b0,4'h0,2'd0, 5'b11111,5'b11111,2'b00,1'b0},
        // R2 space 11 gives no cycle
        '{4'd2, 1'b0,1'b1,1'b0,1'b0,1'b1, 2'd3,1'b0,4'h0,2'd0, 5'b11111,5'b11111,2'b00,1'b0},
        // R6 dma read socket 0, wide
        '{4'd6, 1'b1,1'b1,1'b0,1'b0,1'b1, 2'd0,1'b0,4'h1,2'd0, 5'b11111,5'b11011,2'b01,1'b0},
        // R6 dma write socket 1, sel points at 0
        '{4'd6, 1'b1,1'b0,1'b1,1'b0,1'b0, 2'd0,1'b0,4'h8,2'd0, 5'b11101,5'b11111,2'b00,1'b0},
        // R7 dma read with tc, mode 3
        '{4'd7, 1'b1,1'b1,1'b0,1'b1,1'b0, 2'd1,1'b0,4'h3,2'd0, 5'b11111,5'b00011,2'b00,1'b0},
        // R7 R10 dma write with tc socket 1, wide
        '{4'd7, 1'b1,1'b0,1'b1,1'b1,1'b1, 2'd2,1'b0,4'h4,2'd0, 5'b00101,5'b11111,2'b10,1'b0},
        // R8 dack ignored: io read socket 1
        '{4'd8, 1'b1,1'b1,1'b0,1'b0,1'b0, 2'd2,1'b1,4'h0,2'd0, 5'b11010,5'b11111,2'b00,1'b0},
        // R8 dack ignored, tc ignored: common write socket 0
        '{4'd8, 1'b1,1'b0,1'b1,1'b1,1'b0, 2'd0,1'b0,4'h0,2'd0, 5'b11111,5'b10111,2'b00,1'b0},
        // R9 both enabled: socket 0 wins despite sel 1
        '{4'd9, 1'b1,1'b1,1'b0,1'b0,1'b0, 2'd0,1'b1,4'h5,2'd0, 5'b11111,5'b11011,2'b00,1'b0},
        // R11 masked request from socket 1
        '{4'd11,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,1'b0,4'h1,2'd2, 5'b11111,5'b11111,2'b00,1'b0},
        // R11 socket 0 request forwarded
        '{4'd11,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,1'b0,4'h1,2'd1, 5'b11111,5'b11111,2'b00,1'b1},
        // R11 socket 1 request forwarded
        '{4'd11,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,1'b0,4'h4,2'd2, 5'b11111,5'b11111,2'b00,1'b1},
        // R9 R11 both enabled: socket 1 request masked
        '{4'd9, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,1'b0,4'h5,2'd2, 5'b11111,5'b11111,2'b00,1'b0},
        // R11 nothing enabled
        '{4'd11,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,1'b0,4'h0,2'd3, 5'b11111,5'b11111,2'b00,1'b0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             host_dack, host_rd, host_wr, host_tc, host_wide;
    logic [1:0]       req_space;
    logic [0:0]       sock_sel;
    logic [3:0]       dma_mode;
    logic [1:0]       card_dreq;
    logic [1:0]       card_oe_n, card_we_n, card_iord_n, card_iowr_n, card_reg_n;
    logic [1:0]       card_wide;
    logic             host_dreq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pcdma_cycle_gen #(.NSOCK(NSOCK), .MODE_W(MODE_W)) dut_i (
        .clk, .rst_n, .host_dack, .host_rd, .host_wr, .host_tc, .host_wide,
        .req_space, .sock_sel, .dma_mode, .card_dreq,
        .card_oe_n, .card_we_n, .card_iord_n, .card_iowr_n, .card_reg_n,
        .card_wide, .host_dreq
    );

    function automatic logic [4:0] sock_strobes(input int s);
        return {card_oe_n[s], card_we_n[s], card_iord_n[s], card_iowr_n[s], card_reg_n[s]};
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        host_dack = v.dack; host_rd = v.rd; host_wr = v.wr; host_tc = v.tc;
        host_wide = v.wide; req_space = v.space; sock_sel = v.sel;
        dma_mode = v.mode; card_dreq = v.dreq;
    endtask

    task automatic check_all(input string tag, input logic [4:0] e1, input logic [4:0] e0,
                             input logic [1:0] ew, input logic ed);
        check(tag, "socket1 strobes", 16'(sock_strobes(1)), 16'(e1));
        check(tag, "socket0 strobes", 16'(sock_strobes(0)), 16'(e0));
        check(tag, "card_wide", 16'(card_wide), 16'(ew));
        check(tag, "host_dreq", 16'(host_dreq), 16'(ed));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset with a live DMA cycle and a forwarded request on the inputs
        apply(VEC[11]);
        card_dreq = 2'b01;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all("R1", 5'b11111, 5'b11111, 2'b00, 1'b0);
        rst_n = 1'b1;
        apply(VEC[0]);
        @(posedge clk);
        @(negedge clk);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
            apply(VEC[i]);
            @(posedge clk);
            @(negedge clk);
            check_all(tag, VEC[i].e1, VEC[i].e0, VEC[i].ewide, VEC[i].edreq);
        end

        // R2: output must not move before the clock edge
        apply(VEC[0]);
        @(posedge clk);
        @(negedge clk);
        apply(VEC[1]);
        #1;
        check("R2", "socket0 before edge", 16'(sock_strobes(0)), 16'(5'b11111));
        @(posedge clk);
        @(negedge clk);
        check("R2", "socket0 after edge", 16'(sock_strobes(0)), 16'(5'b01111));

        // R7: tc toggling across back-to-back DMA cycles
        apply(VEC[11]);
        @(posedge clk);
        @(negedge clk);
        check("R7", "tc high", 16'(sock_strobes(0)), 16'(5'b00011));
        host_tc = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R7", "tc low", 16'(sock_strobes(0)), 16'(5'b11011));

        // R1: mid-run reset while an I/O cycle is being driven
        apply(VEC[5]);
        dma_mode = 4'h1;
        card_dreq = 2'b01;
        host_dack = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1", "io before reset", 16'(sock_strobes(0)), 16'(5'b11010));
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_all("R1", 5'b11111, 5'b11111, 2'b00, 1'b0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R11", "dreq after reset release", 16'(host_dreq), 16'(1'b1));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule